// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Controller

This block is a general-purpose I/O controller with 81 pins, split into three banks of 32, 32 and 17 pins. Each input pin goes through a two-flop synchroniser. A rising or falling transition, when enabled for that pin, sets a sticky status bit. Software acknowledges the status bit by writing 1 to it. Pins 0 and 1 each own a dedicated interrupt line. The status of every other pin is ORed onto one shared interrupt line.

The same block drives the pins. Each pin has a direction bit and an output latch. Separate set and clear registers change the latch, so software never needs a read-modify-write to update it. A level register returns the synchronised pin value in either direction.

All registers sit behind a 32-bit word bus. Writes take effect on the clock edge on which `busWrEn` is high. Reads are combinational from `busAddr`. Each register type takes three consecutive words, one per bank, and the types are spaced 0x0C apart.

Top module: `gpio_edge_irq`

## Requirements
- R1: Register word address = type*0x0C + bank*4. The types are level=0, direction=1, set=2, clear=3, rising enable=4, falling enable=5, status=6. Bit k of a bank word maps to pin bank*32+k. Bits 31..17 of every bank-2 word read as zero.
- R2: An enabled rising transition of the synchronised pin sets the pin's status bit, and so does an enabled falling transition. A pin with both enables set records both kinds of transition. A transition with its enable clear sets nothing.
- R3: A status bit stays set until a write of 1 to that bit of the status register clears it. Writing 0 leaves the bit unchanged.
- R4: `irqPin0` and `irqPin1` are registered copies of the status bits of pins 0 and 1. Those two bits never drive `irqShared`.
- R5: `irqShared` is high, one register later, exactly when any status bit of pins 2..80 is set.
- R6: Writing 1 to a bit of the set register drives that pin's `pinOut` high. Writing 1 to a bit of the clear register drives it low. Zero bits leave the latch unchanged. The set and clear words read back as the latch.
- R7: `pinDir` drives the direction register (1 = output). The level register returns the pin input, delayed by two clocks, whatever the direction.
- R8: After reset, all enables, status bits, direction bits and latches are zero, and all three interrupt outputs are low.
- R9: When an enabled transition and a write-1 clear hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register word |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| pinIn | input | 81 | Asynchronous pin inputs |
| pinOut | output | 81 | Output latch |
| pinDir | output | 81 | Direction, 1 = drive |
| irqPin0 | output | 1 | Dedicated interrupt of pin 0 |
| irqPin1 | output | 1 | Dedicated interrupt of pin 1 |
| irqShared | output | 1 | Interrupt from pins 2..80 |

## Verification
A corrupted status or enable bit shows up as an interrupt line at the wrong level one clock after the status register. It also shows up as a wrong bit in the status word, which can be read the next cycle. A broken synchroniser or transition detector moves the status update away from the third clock after the pin change, and it can record a transition of the wrong polarity. These faults are visible as soon as the bench reads the status word back. Address-decode faults show as data landing in the wrong bank, or as nonzero upper bits in bank 2.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANK_W = 32;
  localparam int BANK_IDX_W = 4;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_NONE  = 3'd7
  } regType_e;

  typedef struct packed {
    logic                  wrDir;
    logic                  wrSet;
    logic                  wrClr;
    logic                  wrRise;
    logic                  wrFall;
    logic                  wrStat;
    logic [BANK_IDX_W-1:0] bank;
    regType_e              rdType;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobes_t      strobes
);
  localparam int NUM_TYPES = 7;

  logic [ADDR_W-3:0] wordIdx;
  int unsigned       typeNum;
  int unsigned       bankNum;
  logic              hit;
  regType_e          regType;

  always_comb begin
    wordIdx = busAddr[ADDR_W-1:2];
    typeNum = 32'(wordIdx) / NUM_BANKS;
    bankNum = 32'(wordIdx) % NUM_BANKS;
    hit     = (busAddr[1:0] == 2'b00) && (typeNum < NUM_TYPES);
    regType = hit ? regType_e'(typeNum[2:0]) : REG_NONE;

    strobes        = '0;
    strobes.bank   = bankNum[BANK_IDX_W-1:0];
    strobes.rdType = regType;
    strobes.wrDir  = busWrEn && (regType == REG_DIR);
    strobes.wrSet  = busWrEn && (regType == REG_SET);
    strobes.wrClr  = busWrEn && (regType == REG_CLR);
    strobes.wrRise = busWrEn && (regType == REG_RISE);
    strobes.wrFall = busWrEn && (regType == REG_FALL);
    strobes.wrStat = busWrEn && (regType == REG_STAT);
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 81,
  parameter int NUM_BANKS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [BANK_W-1:0]   busWdata,
  output logic [BANK_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] latchVec,
  output logic [NUM_PINS-1:0] dirVec,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] riseEnVec,
  output logic [NUM_PINS-1:0] fallEnVec,
  output logic [NUM_PINS-1:0] wrMaskVec,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);
  localparam int PAD_W = NUM_BANKS * BANK_W;

  logic [NUM_PINS-1:0] syncA, syncB, prevB, edgeHit;
  logic [NUM_PINS-1:0] setMask, clrMask, statClrMask;

  // Per-pin slice of the write data, gated by the bank match
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
    localparam int BANK = i / BANK_W;
    localparam int BIT  = i % BANK_W;
    assign wrMaskVec[i] = (32'(strobes.bank) == BANK) && busWdata[BIT];
  end

  assign setMask     = strobes.wrSet  ? wrMaskVec : '0;
  assign clrMask     = strobes.wrClr  ? wrMaskVec : '0;
  assign statClrMask = strobes.wrStat ? wrMaskVec : '0;

  // Transition detect on the synchronised value
  assign edgeHit = (syncB & ~prevB & riseEnVec) | (~syncB & prevB & fallEnVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      prevB     <= '0;
      latchVec  <= '0;
      dirVec    <= '0;
      riseEnVec <= '0;
      fallEnVec <= '0;
      statusVec <= '0;
      irqPin0   <= 1'b0;
      irqPin1   <= 1'b0;
      irqShared <= 1'b0;
    end else begin
      syncA     <= pinIn;
      syncB     <= syncA;
      prevB     <= syncB;
      latchVec  <= (latchVec | setMask) & ~clrMask;
      if (strobes.wrDir)  dirVec    <= (dirVec    & ~bankBits()) | wrMaskVec;
      if (strobes.wrRise) riseEnVec <= (riseEnVec & ~bankBits()) | wrMaskVec;
      if (strobes.wrFall) fallEnVec <= (fallEnVec & ~bankBits()) | wrMaskVec;
      // A new transition overrides a simultaneous acknowledge
      statusVec <= edgeHit | (statusVec & ~statClrMask);
      irqPin0   <= statusVec[0];
      irqPin1   <= statusVec[1];
      irqShared <= |statusVec[NUM_PINS-1:2];
    end
  end

  function automatic logic [NUM_PINS-1:0] bankBits();
    logic [NUM_PINS-1:0] m;
    for (int i = 0; i < NUM_PINS; i++) m[i] = (32'(strobes.bank) == i / BANK_W);
    return m;
  endfunction

  // Read mux: pad each vector to whole banks, upper bank bits stay zero
  logic [PAD_W-1:0] rdVec;
  always_comb begin
    rdVec = '0;
    unique case (strobes.rdType)
      REG_LEVEL:       rdVec[NUM_PINS-1:0] = syncB;
      REG_DIR:         rdVec[NUM_PINS-1:0] = dirVec;
      REG_SET, REG_CLR: rdVec[NUM_PINS-1:0] = latchVec;
      REG_RISE:        rdVec[NUM_PINS-1:0] = riseEnVec;
      REG_FALL:        rdVec[NUM_PINS-1:0] = fallEnVec;
      REG_STAT:        rdVec[NUM_PINS-1:0] = statusVec;
      default:         rdVec = '0;
    endcase
    busRdata = (32'(strobes.bank) < NUM_BANKS) ? rdVec[32'(strobes.bank)*BANK_W +: BANK_W] : '0;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 81,
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinDir,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] statusVec, riseEnVec, fallEnVec, wrMaskVec;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  gpio_edge_dp #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinIn     (pinIn),
    .latchVec  (pinOut),
    .dirVec    (pinDir),
    .statusVec (statusVec),
    .riseEnVec (riseEnVec),
    .fallEnVec (fallEnVec),
    .wrMaskVec (wrMaskVec),
    .irqPin0   (irqPin0),
    .irqPin1   (irqPin1),
    .irqShared (irqShared)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 81,
  parameter int NUM_BANKS = 3
) (
  input logic                clk,
  input logic                rstN,
  input ctrlStrobes_t        strobes,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] riseEnVec,
  input logic [NUM_PINS-1:0] fallEnVec,
  input logic [NUM_PINS-1:0] wrMaskVec,
  input logic [NUM_PINS-1:0] pinOut,
  input logic                irqPin0,
  input logic                irqPin1,
  input logic                irqShared
);
  localparam int LAST_W = NUM_PINS - (NUM_BANKS - 1) * BANK_W;

  AST_BANK2_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (32'(strobes.bank) == NUM_BANKS - 1) |-> ((busRdata >> LAST_W) == '0)); // R1

  AST_NO_EDGE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (riseEnVec == '0 && fallEnVec == '0) |=> ((statusVec & ~$past(statusVec)) == '0)); // R2

  AST_CLEAR_ONLY_BY_W1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusVec) & ~statusVec &
               ~($past(strobes.wrStat) ? $past(wrMaskVec) : '0)) == '0)); // R3

  AST_IRQ0_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[0] |=> irqPin0); // R4

  AST_IRQ1_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !statusVec[1] |=> !irqPin1); // R4

  AST_SHARED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[NUM_PINS-1:2] == '0) |=> !irqShared); // R5

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSet |=> ((pinOut & $past(wrMaskVec)) == $past(wrMaskVec))); // R6

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrClr |=> ((pinOut & $past(wrMaskVec)) == '0)); // R6
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strobes   (strobes),
  .busRdata  (busRdata),
  .statusVec (statusVec),
  .riseEnVec (riseEnVec),
  .fallEnVec (fallEnVec),
  .wrMaskVec (wrMaskVec),
  .pinOut    (pinOut),
  .irqPin0   (irqPin0),
  .irqPin1   (irqPin1),
  .irqShared (irqShared)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int NP = 81;
  localparam logic [7:0] A_LEVEL = 8'h00, A_DIR = 8'h0C, A_SET = 8'h18, A_CLR = 8'h24,
                         A_RISE = 8'h30, A_FALL = 8'h3C, A_STAT = 8'h48;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NP-1:0] pinIn = '0, pinOut, pinDir;
  logic irqPin0, irqPin1, irqShared;

  int checks = 0, errors = 0;
  logic [NP-1:0] expStat = '0, expRise = '0, expFall = '0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (.*);

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bankOf(logic [NP-1:0] v, int b);
    logic [95:0] p = 96'(v);
    return p[b*32 +: 32];
  endfunction

  function automatic logic [NP-1:0] place(logic [31:0] d, int b);
    logic [95:0] p = '0;
    p[b*32 +: 32] = d;
    return p[NP-1:0];
  endfunction

  task automatic wr(logic [7:0] a, int b, logic [31:0] d);
    @(negedge clk);
    busAddr = a + 8'(b * 4); busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, int b);
    @(negedge clk);
    busAddr = a + 8'(b * 4);
    #1 rd = busRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply a pin pattern and update the model for enabled transitions
  task automatic drivePins(logic [NP-1:0] nv);
    logic [NP-1:0] ov = pinIn;
    @(negedge clk);
    pinIn = nv;
    expStat |= (nv & ~ov & expRise) | (~nv & ov & expFall);
    waitCyc(6);
  endtask

  task automatic checkIrqs(string tag);
    check({tag, " R4 irqPin0"}, 96'(irqPin0), 96'(expStat[0]));
    check({tag, " R4 irqPin1"}, 96'(irqPin1), 96'(expStat[1]));
    check({tag, " R5 irqShared"}, 96'(irqShared), 96'(|expStat[NP-1:2]));
  endtask

  task automatic checkStatus(string tag);
    for (int b = 0; b < 3; b++) begin
      rdReg(A_STAT, b);
      check({tag, " R3 status word"}, 96'(rd), 96'(bankOf(expStat, b)));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R8 reset state
    checkIrqs("R8");
    check("R8 pinOut", 96'(pinOut), 96'(0));
    check("R8 pinDir", 96'(pinDir), 96'(0));
    rdReg(A_RISE, 1); check("R8 rise enable", 96'(rd), 96'(0));

    // R8/R2: transitions with all enables off record nothing
    drivePins({NP{1'b1}});
    drivePins('0);
    checkStatus("R2 disabled");

    // R7 level readback and direction
    @(negedge clk); pinIn = place(32'h1_5A5A, 2); waitCyc(3);
    rdReg(A_LEVEL, 2); check("R7 level bank2", 96'(rd), 96'(32'h1_5A5A));
    wr(A_DIR, 1, 32'hF00F_0001);
    check("R7 pinDir", 96'(pinDir), 96'(place(32'hF00F_0001, 1)));
    rdReg(A_DIR, 1); check("R7 dir readback", 96'(rd), 96'(32'hF00F_0001));
    @(negedge clk); pinIn = '0; waitCyc(3);

    // R1 bank 2 upper bits read zero even after all-ones write
    wr(A_RISE, 2, 32'hFFFF_FFFF);
    rdReg(A_RISE, 2); check("R1 bank2 pad", 96'(rd), 96'(32'h0001_FFFF));
    expRise = place(32'h0001_FFFF, 2);

    // R6 set and clear
    wr(A_SET, 0, 32'h8000_0003);
    check("R6 set", 96'(pinOut), 96'(place(32'h8000_0003, 0)));
    wr(A_CLR, 0, 32'h0000_0001);
    check("R6 clear", 96'(pinOut), 96'(place(32'h8000_0002, 0)));
    wr(A_SET, 2, 32'h0);
    check("R6 zero write", 96'(pinOut), 96'(place(32'h8000_0002, 0)));
    rdReg(A_CLR, 0); check("R6 latch readback", 96'(rd), 96'(32'h8000_0002));

    // R2 both edges on pin 0, R4 dedicated line
    wr(A_RISE, 0, 32'h1); wr(A_FALL, 0, 32'h1);
    expRise = place(32'h1, 0) | place(32'h0001_FFFF, 2);
    expFall = place(32'h1, 0);
    drivePins(place(32'h1, 0));
    checkIrqs("R2 rise pin0");
    wr(A_STAT, 0, 32'h0);              // R3 writing 0 keeps the bit
    checkIrqs("R3 w0");
    wr(A_STAT, 0, 32'h1); expStat[0] = 1'b0; waitCyc(2);
    checkIrqs("R3 w1c");
    drivePins('0);
    checkIrqs("R2 fall pin0");
    wr(A_STAT, 0, 32'h1); expStat[0] = 1'b0; waitCyc(2);

    // R9 transition and clear in the same cycle: bit stays set
    wr(A_FALL, 0, 32'h21); expFall = place(32'h21, 0);
    wr(A_RISE, 0, 32'h21); expRise = place(32'h21, 0) | place(32'h0001_FFFF, 2);
    drivePins(place(32'h20, 0));
    @(negedge clk); pinIn = '0;          // status sets on the third rising edge
    @(negedge clk); @(negedge clk);
    busAddr = A_STAT; busWdata = 32'h20; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    waitCyc(3);
    rdReg(A_STAT, 0); check("R9 edge beats clear", 96'(rd), 96'(32'h20));
    wr(A_STAT, 0, 32'h20); expStat = '0; waitCyc(2);
    checkIrqs("R5 cleared");

    // Random phase
    for (int it = 0; it < 60; it++) begin
      int b = int'($urandom_range(0, 2));
      logic [31:0] r = $urandom, f = $urandom;
      logic [NP-1:0] mask = place(b == 2 ? 32'h1_FFFF : 32'hFFFF_FFFF, b);
      wr(A_RISE, b, r); wr(A_FALL, b, f);
      expRise = (expRise & ~mask) | (place(r, b) & mask);
      expFall = (expFall & ~mask) | (place(f, b) & mask);
      drivePins(NP'({$urandom, $urandom, $urandom}));
      checkIrqs("rand");
      if (it % 3 == 0) begin
        logic [31:0] c = $urandom;
        int cb = int'($urandom_range(0, 2));
        wr(A_STAT, cb, c);
        expStat &= ~place(c, cb);
        waitCyc(2);
        checkIrqs("rand clr");
      end
      if (it % 10 == 0) checkStatus("rand");
    end
    checkStatus("final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule